// File: doc/BRIEF.md
# Legacy-Replacement Interrupt Router

This block sits between a bank of timer channels and the interrupt lines of a platform. Each channel presents a fire strobe, a clear strobe, an enable, a delivery type and a 5-bit line number. The router turns those into drive on a bank of 32 interrupt output lines. It also carries two external interrupt inputs, a periodic-tick input and a real-time-clock input, through to fixed lines.

A legacy-replacement mode input changes the routing. While the mode is active, channel 0 takes the periodic-tick line (line 0) and channel 1 takes the real-time-clock line (line 8), and both external inputs are shut off. A tick-source enable output tells the platform whether its own tick source should run.

The mode is tracked by a two-state machine with states NORMAL and LEGACY. Transition ENTER goes from NORMAL to LEGACY when the mode input is seen high. Transition EXIT goes from LEGACY to NORMAL when the mode input is seen low. HOLD is the name for every cycle with no transition. The block keeps the last real-time-clock level at all times, so that line 8 is restored correctly on EXIT.

Top module: `lrr_irq_router`

## Requirements
- R1: While reset is held and in the first cycle after it, every interrupt line is low and `tick_src_en` is high.
- R2: With the mode input low, channel i drives line `ch_route[5*i+4 : 5*i]`. Channel 0 uses bits [4:0].
- R3: With the mode input high, channel 0 drives line 0 and channel 1 drives line 8, whatever their route fields hold. Channels 2 and up keep using their route field.
- R4: A level-type channel (`ch_level`=1) that fires raises its line on the next clock edge. The line stays high until `ch_clr` is seen. When fire and clear fall in the same cycle, clear wins.
- R5: An edge-type channel (`ch_level`=0) drives its line high for one cycle after each cycle in which it fires, and holds nothing afterwards.
- R6: When `ch_en` or `glb_en` is low, the channel's line drops on the next edge and its level request is discarded. After re-enable, the line stays low until the channel fires again.
- R7: In steady NORMAL, line 0 also carries `tick_in` and line 8 also carries `rtc_in`, one cycle late. While the mode input is high, neither input reaches any line.
- R8: When several sources map to one line, the line is the OR of all their requests and pulses.
- R9: On the ENTER transition, lines 0 and 8 are low on the next edge, overriding every source, and `tick_src_en` goes low and stays low while in LEGACY.
- R10: On the EXIT transition, line 0 is low on the next edge, line 8 equals the `rtc_in` value sampled one edge earlier (overriding every other source), and `tick_src_en` goes high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| glb_en | input | 1 | Global enable for channel interrupt delivery |
| legacy_sel | input | 1 | Legacy-replacement mode bit, already registered upstream |
| ch_en | input | N_CH | Per-channel interrupt enable |
| ch_level | input | N_CH | Per-channel type: 1 = level, 0 = edge |
| ch_fire | input | N_CH | Per-channel expiry strobe |
| ch_clr | input | N_CH | Per-channel request clear strobe |
| ch_route | input | N_CH*ROUTE_W | Per-channel target line numbers, packed |
| tick_in | input | 1 | External periodic-tick interrupt input |
| rtc_in | input | 1 | External real-time-clock interrupt input |
| irq_out | output | 2**ROUTE_W | Interrupt output lines |
| tick_src_en | output | 1 | Enable for the external tick source |

## Verification
Every result, whether line drive, transition override or tick-source enable, is registered once. Each is therefore due exactly one rising edge after the inputs that cause it, and a held level line stays at that value on every later edge until a clear or disable is seen. The bench changes inputs only after a falling edge. It predicts the outputs from those inputs and its own mode, request and latched-level state, then compares them 2 ns after the next rising edge. The latched real-time-clock value used on EXIT is the one the bench saw before the previous edge.

// File: rtl/lrr_pkg.sv
package lrr_pkg;

    typedef enum logic [0:0] {
        MODE_NORMAL = 1'b0,
        MODE_LEGACY = 1'b1
    } lrr_mode_e;

    typedef enum logic [1:0] {
        EV_HOLD  = 2'd0,
        EV_ENTER = 2'd1,
        EV_EXIT  = 2'd2
    } lrr_event_e;

    // fixed lines taken over in legacy-replacement mode
    localparam int unsigned TICK_LINE = 0;
    localparam int unsigned RTC_LINE  = 8;

endpackage

// File: rtl/lrr_chan.sv
module lrr_chan
    import lrr_pkg::*;
#(
    parameter int unsigned ROUTE_W = 5,
    parameter int unsigned CH_IDX  = 0,
    localparam int unsigned NUM_LINES = 1 << ROUTE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 glb_en,
    input  logic                 legacy_sel,
    input  logic                 en,
    input  logic                 level,
    input  logic                 fire,
    input  logic                 clr,
    input  logic [ROUTE_W-1:0]   route,
    output logic [NUM_LINES-1:0] drive
);

    localparam bit HAS_FIXED = (CH_IDX < 2);
    localparam logic [ROUTE_W-1:0] FIXED_LINE =
        (CH_IDX == 0) ? ROUTE_W'(TICK_LINE) : ROUTE_W'(RTC_LINE);

    logic               gate;
    logic               pend_q;
    logic               pend_n;
    logic               active;
    logic [ROUTE_W-1:0] tgt;

    assign gate   = en & glb_en;
    // clear takes priority over a simultaneous fire
    assign pend_n = gate & level & ~clr & (pend_q | fire);
    assign active = level ? pend_n : (gate & fire);
    assign tgt    = (HAS_FIXED && legacy_sel) ? FIXED_LINE : route;
    assign drive  = active ? (NUM_LINES'(1) << tgt) : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pend_n;
    end

    // R4
    clr_drops_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !pend_q);

    // R6
    gate_drops_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(en && glb_en) |=> !pend_q);

endmodule

// File: rtl/lrr_mode_fsm.sv
module lrr_mode_fsm
    import lrr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       legacy_sel,
    output lrr_mode_e  state,
    output lrr_event_e ev,
    output logic       tick_src_en
);

    lrr_mode_e state_n;

    always_comb begin
        state_n = state;
        ev      = EV_HOLD;
        unique case (state)
            MODE_NORMAL: if (legacy_sel) begin
                state_n = MODE_LEGACY;
                ev      = EV_ENTER;
            end
            MODE_LEGACY: if (!legacy_sel) begin
                state_n = MODE_NORMAL;
                ev      = EV_EXIT;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= MODE_NORMAL;
        else        state <= state_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_src_en <= 1'b1;
        end else begin
            unique case (ev)
                EV_ENTER: tick_src_en <= 1'b0;
                EV_EXIT:  tick_src_en <= 1'b1;
                default:  tick_src_en <= tick_src_en;
            endcase
        end
    end

    // R9
    enter_stops_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == MODE_NORMAL && legacy_sel) |=> (!tick_src_en && state == MODE_LEGACY));

    // R10
    exit_starts_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == MODE_LEGACY && !legacy_sel) |=> (tick_src_en && state == MODE_NORMAL));

endmodule

// File: rtl/lrr_line_mux.sv
module lrr_line_mux
    import lrr_pkg::*;
#(
    parameter int unsigned N_CH    = 4,
    parameter int unsigned ROUTE_W = 5,
    localparam int unsigned NUM_LINES = 1 << ROUTE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] drv [N_CH],
    input  lrr_mode_e            state,
    input  lrr_event_e           ev,
    input  logic                 tick_in,
    input  logic                 rtc_in,
    output logic [NUM_LINES-1:0] irq_out
);

    logic                 rtc_lat;
    logic [NUM_LINES-1:0] lines_n;

    always_comb begin
        lines_n = '0;
        for (int i = 0; i < int'(N_CH); i++) lines_n |= drv[i];
        unique case (ev)
            EV_ENTER: begin
                lines_n[TICK_LINE] = 1'b0;
                lines_n[RTC_LINE]  = 1'b0;
            end
            EV_EXIT: begin
                lines_n[TICK_LINE] = 1'b0;
                lines_n[RTC_LINE]  = rtc_lat;
            end
            default: if (state == MODE_NORMAL) begin
                lines_n[TICK_LINE] = lines_n[TICK_LINE] | tick_in;
                lines_n[RTC_LINE]  = lines_n[RTC_LINE] | rtc_in;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_out <= '0;
            rtc_lat <= 1'b0;
        end else begin
            irq_out <= lines_n;
            rtc_lat <= rtc_in;
        end
    end

    // R9
    enter_lowers_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_ENTER) |=> (!irq_out[TICK_LINE] && !irq_out[RTC_LINE]));

    // R10
    exit_restores_rtc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_EXIT) |=> (!irq_out[TICK_LINE] && irq_out[RTC_LINE] == $past(rtc_lat)));

endmodule

// File: rtl/lrr_irq_router.sv
module lrr_irq_router
    import lrr_pkg::*;
#(
    parameter int unsigned N_CH    = 4,
    parameter int unsigned ROUTE_W = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      glb_en,
    input  logic                      legacy_sel,
    input  logic [N_CH-1:0]           ch_en,
    input  logic [N_CH-1:0]           ch_level,
    input  logic [N_CH-1:0]           ch_fire,
    input  logic [N_CH-1:0]           ch_clr,
    input  logic [N_CH*ROUTE_W-1:0]   ch_route,
    input  logic                      tick_in,
    input  logic                      rtc_in,
    output logic [(1<<ROUTE_W)-1:0]   irq_out,
    output logic                      tick_src_en
);

    localparam int unsigned NUM_LINES = 1 << ROUTE_W;

    logic [NUM_LINES-1:0] drv [N_CH];
    lrr_mode_e            state;
    lrr_event_e           ev;

    for (genvar g = 0; g < N_CH; g++) begin : g_chan
        lrr_chan #(
            .ROUTE_W (ROUTE_W),
            .CH_IDX  (g)
        ) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .glb_en     (glb_en),
            .legacy_sel (legacy_sel),
            .en         (ch_en[g]),
            .level      (ch_level[g]),
            .fire       (ch_fire[g]),
            .clr        (ch_clr[g]),
            .route      (ch_route[g*ROUTE_W +: ROUTE_W]),
            .drive      (drv[g])
        );
    end

    lrr_mode_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .legacy_sel  (legacy_sel),
        .state       (state),
        .ev          (ev),
        .tick_src_en (tick_src_en)
    );

    lrr_line_mux #(
        .N_CH    (N_CH),
        .ROUTE_W (ROUTE_W)
    ) u_mux (
        .clk     (clk),
        .rst_n   (rst_n),
        .drv     (drv),
        .state   (state),
        .ev      (ev),
        .tick_in (tick_in),
        .rtc_in  (rtc_in),
        .irq_out (irq_out)
    );

    // R6
    glb_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!glb_en && legacy_sel && state == MODE_LEGACY) |=> (irq_out == '0));

    // R7
    legacy_blocks_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (legacy_sel && state == MODE_LEGACY && !glb_en && (tick_in || rtc_in))
            |=> (!irq_out[TICK_LINE] && !irq_out[RTC_LINE]));

endmodule

// File: tb/sim_lrr_irq_router.sv
`timescale 1ns/1ps
module sim_lrr_irq_router;

    localparam int N_CH = 4;
    localparam int RW   = 5;
    localparam int NL   = 1 << RW;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            glb_en;
    logic            legacy_sel;
    logic [N_CH-1:0] ch_en, ch_level, ch_fire, ch_clr;
    logic [N_CH*RW-1:0] ch_route;
    logic            tick_in, rtc_in;
    logic [NL-1:0]   irq_out;
    logic            tick_src_en;

    int n_chk  = 0;
    int n_fail = 0;

    // bench prediction state
    logic            m_mode, m_tick, m_rtc;
    logic [N_CH-1:0] m_pend;

    always #10 clk = ~clk;

    lrr_irq_router #(.N_CH(N_CH), .ROUTE_W(RW)) u0 (
        .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .legacy_sel(legacy_sel),
        .ch_en(ch_en), .ch_level(ch_level), .ch_fire(ch_fire), .ch_clr(ch_clr),
        .ch_route(ch_route), .tick_in(tick_in), .rtc_in(rtc_in),
        .irq_out(irq_out), .tick_src_en(tick_src_en)
    );

    task automatic tick(input string tag);
        logic [NL-1:0]   e;
        logic            ep, g, pn, act, rtc_s;
        logic [RW-1:0]   tg;
        logic [N_CH-1:0] pnv;
        e = '0;
        for (int i = 0; i < N_CH; i++) begin
            g      = ch_en[i] & glb_en;
            pn     = g & ch_level[i] & ~ch_clr[i] & (m_pend[i] | ch_fire[i]);
            pnv[i] = pn;
            act    = ch_level[i] ? pn : (g & ch_fire[i]);
            if (legacy_sel && i == 0)      tg = 5'd0;
            else if (legacy_sel && i == 1) tg = 5'd8;
            else                           tg = ch_route[i*RW +: RW];
            if (act) e[tg] = 1'b1;
        end
        if (legacy_sel && !m_mode) begin
            e[0] = 1'b0; e[8] = 1'b0; ep = 1'b0;
        end else if (!legacy_sel && m_mode) begin
            e[0] = 1'b0; e[8] = m_rtc; ep = 1'b1;
        end else begin
            ep = m_tick;
            if (!legacy_sel) begin
                e[0] = e[0] | tick_in;
                e[8] = e[8] | rtc_in;
            end
        end
        rtc_s = rtc_in;
        @(posedge clk);
        #2;
        n_chk++;
        if (irq_out !== e || tick_src_en !== ep) begin
            n_fail++;
            $display("FAIL %s irq_out=%h expected=%h tick_src_en=%b expected=%b",
                     tag, irq_out, e, tick_src_en, ep);
        end
        m_pend = pnv;
        m_mode = legacy_sel;
        m_tick = ep;
        m_rtc  = rtc_s;
        @(negedge clk);
    endtask

    task automatic set_route(input int c, input int r);
        ch_route[c*RW +: RW] = RW'(r);
    endtask

    initial begin
        #(20 * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; glb_en = 1'b1; legacy_sel = 1'b0;
        ch_en = '0; ch_level = '0; ch_fire = '0; ch_clr = '0; ch_route = '0;
        tick_in = 1'b1; rtc_in = 1'b1;
        m_mode = 1'b0; m_tick = 1'b1; m_rtc = 1'b0; m_pend = '0;
        repeat (3) @(negedge clk);
        // R1: reset state even with external inputs high
        n_chk++;
        if (irq_out !== '0 || tick_src_en !== 1'b1) begin
            n_fail++;
            $display("FAIL R1 irq_out=%h expected=0 tick_src_en=%b expected=1", irq_out, tick_src_en);
        end
        tick_in = 1'b0; rtc_in = 1'b0;
        rst_n = 1'b1;
        tick("R1");

        // R2 / R5: every channel to every line, edge type
        for (int c = 0; c < N_CH; c++) begin
            for (int r = 0; r < NL; r++) begin
                ch_en[c] = 1'b1; ch_level[c] = 1'b0; set_route(c, r);
                ch_fire[c] = 1'b1;
                tick("R2");
                ch_fire[c] = 1'b0;
                tick("R5");
                ch_en[c] = 1'b0;
            end
        end

        // R5: fire held two cycles gives two pulse cycles, then nothing
        ch_en[3] = 1'b1; set_route(3, 20); ch_fire[3] = 1'b1;
        tick("R5"); tick("R5");
        ch_fire[3] = 1'b0;
        tick("R5");
        ch_en[3] = 1'b0;

        // R4: level hold and clear priority
        ch_en[2] = 1'b1; ch_level[2] = 1'b1; set_route(2, 3);
        ch_fire[2] = 1'b1; tick("R4");
        ch_fire[2] = 1'b0; tick("R4"); tick("R4"); tick("R4");
        ch_clr[2] = 1'b1; tick("R4");
        ch_clr[2] = 1'b0; tick("R4");
        ch_fire[2] = 1'b1; ch_clr[2] = 1'b1; tick("R4");
        ch_fire[2] = 1'b0; ch_clr[2] = 1'b0; tick("R4");

        // R6: global and channel disable discard the request
        ch_fire[2] = 1'b1; tick("R6");
        ch_fire[2] = 1'b0; glb_en = 1'b0; tick("R6");
        glb_en = 1'b1; tick("R6"); tick("R6");
        ch_fire[2] = 1'b1; tick("R6");
        ch_fire[2] = 1'b0; ch_en[2] = 1'b0; tick("R6");
        ch_en[2] = 1'b1; tick("R6");
        glb_en = 1'b0; ch_fire[2] = 1'b1; tick("R6");
        ch_fire[2] = 1'b0; glb_en = 1'b1; tick("R6");

        // R8: three sources sharing line 7
        set_route(2, 7); ch_en[3] = 1'b1; ch_level[3] = 1'b0; set_route(3, 7);
        ch_en[0] = 1'b1; ch_level[0] = 1'b0; set_route(0, 7);
        ch_fire[2] = 1'b1; tick("R8");
        ch_fire[2] = 1'b0; ch_fire[3] = 1'b1; tick("R8");
        ch_fire[3] = 1'b0; ch_clr[2] = 1'b1; ch_fire[0] = 1'b1; tick("R8");
        ch_clr[2] = 1'b0; ch_fire[0] = 1'b0; tick("R8");
        // R8: channel and pass-through sharing line 0 and line 8
        set_route(0, 0); set_route(3, 8);
        ch_fire[0] = 1'b1; tick_in = 1'b1; tick("R8");
        ch_fire[0] = 1'b0; ch_fire[3] = 1'b1; rtc_in = 1'b1; tick("R8");
        ch_fire[3] = 1'b0; tick_in = 1'b0; rtc_in = 1'b0; tick("R8");
        ch_en = '0; ch_level = '0;

        // R7: external inputs in steady NORMAL, all four patterns
        for (int p = 0; p < 4; p++) begin
            tick_in = p[0]; rtc_in = p[1];
            tick("R7");
        end

        // R9 / R10: mode round trips with every latched and current level
        for (int p = 0; p < 4; p++) begin
            tick_in = 1'b1; rtc_in = p[0];
            legacy_sel = 1'b1; tick("R9");
            tick("R7"); tick("R9");
            rtc_in = p[0]; tick("R7");
            legacy_sel = 1'b0; rtc_in = p[1]; tick("R10");
            tick("R7");
        end

        // R9: ENTER overrides a channel mapped onto line 0
        ch_en[0] = 1'b1; ch_fire[0] = 1'b1;
        legacy_sel = 1'b1; tick("R9");
        ch_fire[0] = 1'b0; ch_en[0] = 1'b0;
        tick_in = 1'b1; rtc_in = 1'b1;

        // R3: legacy routing, level type, every route value
        for (int c = 0; c < N_CH; c++) begin
            for (int r = 0; r < NL; r++) begin
                ch_en[c] = 1'b1; ch_level[c] = 1'b1; set_route(c, r);
                ch_fire[c] = 1'b1; tick("R3");
                ch_fire[c] = 1'b0; ch_clr[c] = 1'b1; tick("R3");
                ch_clr[c] = 1'b0; ch_en[c] = 1'b0;
            end
        end

        // R10: EXIT overrides a held level request on line 8
        ch_en[1] = 1'b1; ch_level[1] = 1'b1; ch_fire[1] = 1'b1;
        rtc_in = 1'b0; tick("R3");
        ch_fire[1] = 1'b0; set_route(1, 8);
        legacy_sel = 1'b0; tick("R10");
        tick("R7");
        ch_en = '0;
        tick("R7");

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule